// File: doc/BRIEF.md
# Shared Timer Clock Prescaler with Per-Channel Source Select

This block produces the count-enable strobes for a set of timer channels that share one divider. A counter (10 bits by default) advances on every system clock. Its low-order bit groups give four divided rates: 1/8, 1/64, 1/256 and 1/1024. Each channel has its own 3-bit source code. The code picks one of four sources: no counting, every clock, one of the divided rates, or an edge of that channel's external pin. The channel then emits a one-cycle enable pulse on each qualifying event. The timer counters that consume these pulses sit outside the block.

The external pin is not used as a clock. It goes through a two-stage synchronizer into the system clock domain. An edge detector then compares the synchronized level with the previous sample, so every count stays synchronous to the system clock. A single clear strobe sets the shared counter back to zero. This aligns the divided rates of all channels at the same moment. The counter keeps running in every other case, whatever the channels have selected.

Top module: `shared_prescaler`

## Requirements
- R1: While reset is asserted, and after reset until a channel selects a source, every enable output is 0.
- R2: Code 3'b000 stops a channel: its enable output stays 0.
- R3: Code 3'b001 makes the channel's enable 1 in every cycle.
- R4: Codes 3'b010, 3'b011, 3'b100 and 3'b101 select divide-by 8, 64, 256 and 1024. For divide-by-N the enable is 1 in the cycle after the shared counter's low log2(N) bits are all zero. This gives exactly one pulse every N cycles.
- R5: The shared counter advances every clock whatever codes are selected. A channel that switches from stop to a divided rate picks up the existing phase and does not restart it.
- R6: A clear strobe sets the shared counter to zero at the next clock edge for all channels together. Every divided rate then pulses in the cycle after that edge.
- R7: Code 3'b111 gives one enable pulse per rising edge of the channel's pin. The pulse appears in the cycle after the third clock edge, counting the first edge at which the new pin level is sampled.
- R8: Code 3'b110 does the same for falling edges of the pin.
- R9: A pin held at a constant level produces no pulses. A pin edge produces exactly one pulse.
- R10: A new code applies from the next clock edge. The enable in a cycle depends only on the code and the source state just before the edge that opens that cycle, so no extra or glitch pulses occur.
- R11: Channels are independent: the code and pin of one channel do not change the enable of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psc_clr_i | input | 1 | Strobe that sets the shared counter to zero |
| sel_i | input | 3*NCH | Source code per channel; channel c uses bits [3c+2:3c] |
| ext_pin_i | input | NCH | External count pin per channel, asynchronous |
| cnt_en_o | output | NCH | One-cycle count-enable pulse per channel |

## Verification
Each enable is registered. A divided-rate or every-clock pulse therefore shows up in the cycle after the edge at which the counter state and code are seen. A pin edge needs three edges: two synchronizer stages and the edge-detector register. The bench drives inputs on the falling clock edge. Before each rising edge it computes the expected enable from its own model of the counter and the synchronizer history, and it compares on the following falling edge. Internal reset is released two edges after the reset port. The bench therefore starts its model at a clear strobe, so the counter phase is known without looking inside the design.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

  typedef enum logic [2:0] {
    SEL_OFF      = 3'b000,
    SEL_DIV1     = 3'b001,
    SEL_DIV8     = 3'b010,
    SEL_DIV64    = 3'b011,
    SEL_DIV256   = 3'b100,
    SEL_DIV1024  = 3'b101,
    SEL_EXT_FALL = 3'b110,
    SEL_EXT_RISE = 3'b111
  } clk_sel_e;

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_TAPS = 4;

  // Number of low counter bits that must be zero for each divided tap.
  function automatic int unsigned tap_shift(input int unsigned idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/psc_rst_sync.sv
module psc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/psc_counter.sv
module psc_counter
  import prescale_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  output logic [NUM_TAPS-1:0] tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    localparam int unsigned SH = tap_shift(t);
    assign tick_o[t] = (cnt_q[SH-1:0] == '0);
  end

  // R5: the counter advances every clock unless cleared
  a_r5_free_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q == $past(cnt_q) + 1'b1);

  // R6: a clear strobe leaves the counter at zero
  a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> tick_o == {NUM_TAPS{1'b1}});

endmodule

// File: rtl/psc_pin_edge.sv
module psc_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    prev_d = sync_q[LAST];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[LAST] & ~prev_q;
  assign fall_o = ~sync_q[LAST] & prev_q;

  // R9: one detected edge never yields two consecutive strobes
  a_r9_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  a_r9_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

endmodule

// File: rtl/psc_clk_mux.sv
module psc_clk_mux
  import prescale_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_TAPS-1:0] tick_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                en_o
);

  clk_sel_e sel;
  logic     en_d;
  logic     en_q;

  assign sel = clk_sel_e'(sel_i);

  always_comb begin
    case (sel)
      SEL_OFF:      en_d = 1'b0;
      SEL_DIV1:     en_d = 1'b1;
      SEL_DIV8:     en_d = tick_i[0];
      SEL_DIV64:    en_d = tick_i[1];
      SEL_DIV256:   en_d = tick_i[2];
      SEL_DIV1024:  en_d = tick_i[3];
      SEL_EXT_FALL: en_d = fall_i;
      default:      en_d = rise_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  // R2: stopped channel gives no pulse
  a_r2_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b000 |=> !en_o);

  // R3: undivided selection pulses every cycle
  a_r3_every_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b001 |=> en_o);

  // R7: rising mode without a detected rising edge gives no pulse
  a_r7_rise_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b111 && !rise_i) |=> !en_o);

  // R8: falling mode without a detected falling edge gives no pulse
  a_r8_fall_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b110 && !fall_i) |=> !en_o);

endmodule

// File: rtl/shared_prescaler.sv
module shared_prescaler
  import prescale_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 psc_clr_i,
  input  logic [NCH*SEL_W-1:0] sel_i,
  input  logic [NCH-1:0]       ext_pin_i,
  output logic [NCH-1:0]       cnt_en_o
);

  logic                rst_n;
  logic [NUM_TAPS-1:0] tick;

  psc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  psc_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (psc_clr_i),
    .tick_o (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic rise;
    logic fall;

    psc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .pin_i  (ext_pin_i[c]),
      .rise_o (rise),
      .fall_o (fall)
    );

    psc_clk_mux i_mux (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .sel_i  (sel_i[c*SEL_W +: SEL_W]),
      .tick_i (tick),
      .rise_i (rise),
      .fall_i (fall),
      .en_o   (cnt_en_o[c])
    );
  end

  // R1: outputs stay low while the internal reset is held
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_n |=> cnt_en_o == '0 || rst_n);

endmodule

// File: tb/test_shared_prescaler.sv
module test_shared_prescaler;

  localparam int NCH = 2;

  logic             clk;
  logic             rst_n;
  logic             clr;
  logic [NCH*3-1:0] sel;
  logic [NCH-1:0]   pin;
  logic [NCH-1:0]   en;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // bench model state
  logic [9:0] m_cnt;
  logic [NCH-1:0] s1, s2, pv;
  logic [NCH*3-1:0] last_sel;

  shared_prescaler #(.NCH(NCH)) i_shared_prescaler (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .psc_clr_i (clr),
    .sel_i     (sel),
    .ext_pin_i (pin),
    .cnt_en_o  (en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic model_en(input logic [2:0] s, input logic [9:0] c,
                                    input logic r, input logic f);
    case (s)
      3'b000: return 1'b0;
      3'b001: return 1'b1;
      3'b010: return c[2:0] == 3'd0;
      3'b011: return c[5:0] == 6'd0;
      3'b100: return c[7:0] == 8'd0;
      3'b101: return c == 10'd0;
      3'b110: return f;
      default: return r;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s, input int ch, input bit chg,
                                   input bit cleared);
    string t;
    case (s)
      3'b000: t = "R2";
      3'b001: t = "R3";
      3'b110: t = "R8 R9";
      3'b111: t = "R7 R9";
      default: t = "R4 R5";
    endcase
    if (ch != 0) t = {t, " R11"};
    if (chg)     t = {t, " R10"};
    if (cleared) t = {t, " R6"};
    return t;
  endfunction

  bit prev_clr = 0;

  // One clock: inputs already set at a falling edge; predict, clock, compare.
  task automatic step();
    logic [NCH-1:0] exp_en;
    for (int c = 0; c < NCH; c++) begin
      exp_en[c] = model_en(sel[c*3 +: 3], m_cnt, s2[c] & ~pv[c], ~s2[c] & pv[c]);
    end
    for (int c = 0; c < NCH; c++) begin
      pv[c] = s2[c];
      s2[c] = s1[c];
      s1[c] = pin[c];
    end
    m_cnt = clr ? 10'd0 : m_cnt + 10'd1;
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (en[c] !== exp_en[c]) begin
        failures++;
        $display("FAIL %s ch%0d sel=%b actual=%b expected=%b",
                 tag_of(sel[c*3 +: 3], c, sel[c*3 +: 3] != last_sel[c*3 +: 3], prev_clr),
                 c, sel[c*3 +: 3], en[c], exp_en[c]);
      end
    end
    prev_clr = clr;
    last_sel = sel;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // R7 R8 R9: toggle a pin and hold it, counting pulses seen
  task automatic pin_pulse(input int ch, input logic lvl, input int hold);
    pin[ch] = lvl;
    run(hold);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    rst_n = 1'b0; clr = 1'b0; sel = '0; pin = '0;
    m_cnt = '0; s1 = '0; s2 = '0; pv = '0; last_sel = '0;
    // R1: quiet during reset, even with a source selected
    repeat (3) @(negedge clk);
    sel = {3'b001, 3'b001};
    repeat (2) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (en[c] !== 1'b0) begin
        failures++;
        $display("FAIL R1 ch%0d actual=%b expected=0", c, en[c]);
      end
    end
    sel = '0;
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        checks++;
        if (en[c] !== 1'b0) begin
          failures++;
          $display("FAIL R1 ch%0d after release actual=%b expected=0", c, en[c]);
        end
      end
    end
    // align model: clear strobe with both channels stopped (R6)
    clr = 1'b1; run(1); clr = 1'b0;
    // R3 on ch0, R2 on ch1
    sel = {3'b000, 3'b001}; run(12);
    // R5: ch1 joins /8 mid-phase
    sel = {3'b010, 3'b001}; run(20);
    // R6: clear mid-run with both on /64
    sel = {3'b011, 3'b011}; run(37);
    clr = 1'b1; run(1); clr = 1'b0; run(70);
    // R7 on ch0, R8 on ch1, R9 held levels
    sel = {3'b110, 3'b111};
    pin_pulse(0, 1'b1, 8);
    pin_pulse(1, 1'b1, 8);
    pin_pulse(0, 1'b0, 8);
    pin_pulse(1, 1'b0, 8);
    pin_pulse(0, 1'b1, 1);
    pin_pulse(0, 1'b0, 6);
    // R4: the slow taps
    sel = {3'b100, 3'b101}; run(2100);
    // random mix
    for (int i = 0; i < 9000; i++) begin
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(63) == 0) sel[c*3 +: 3] = 3'($urandom_range(7));
        if ($urandom_range(3) == 0)  pin[c] = ~pin[c];
      end
      clr = ($urandom_range(499) == 0);
      step();
    end
    clr = 1'b0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule